// File: doc/BRIEF.md
# Two-User Spreading Chip Encoder

This block spreads two 8-bit data words, one per user, into unipolar chip streams for a shared optical channel. A load strobe captures both words at once. Each word is then sent serially, most significant bit first. Every data bit lasts exactly seven chips:

- A data 1 sends that user's seven-chip signature.
- A data 0 sends seven zero chips.

Each user has its own signature. It comes from a 3-stage shift register with XOR feedback and a fixed seed, clocked once per chip. Each bit period starts at the beginning of the signature. The two per-user chips are added as integers on every clock. This models optical power adding on one fiber, so each summed chip is 0, 1 or 2.

Control is a two-state machine. `IDLE` waits with all outputs at zero, and the shift registers are held at their seeds. The transition `IDLE -> SEND` happens on a clock edge that sees `load` high. It captures both words and clears the chip and bit counters. In `SEND` the shift registers advance on every clock and the chip counter runs from 0 to 6. When the counter wraps, the data words shift to their next bit. On the 56th chip `word_done` pulses, and the transition `SEND -> IDLE` follows on that same edge. While in `SEND`, `load` is ignored.

Top module: `cdma_spread_encoder`

## Requirements
- R1: After synchronous reset, and on the clock that follows reset, the block is idle: `chip_u1`, `chip_u2`, `chip_sum` and `word_done` are all 0.
- R2: When user 1 sends a data 1, the seven chips for that bit are 1,1,0,0,1,0,1 in time order.
- R3: When user 2 sends a data 1, the seven chips for that bit are 1,1,1,0,0,1,0 in time order.
- R4: A data 0 bit produces seven consecutive 0 chips on that user's stream.
- R5: A word is sent most significant bit first. Each bit occupies exactly 7 chips, and the first chip of every bit is the first chip of the signature. Chip 0 of bit 7 appears on the clock after the edge that accepted `load`.
- R6: `chip_sum` is the arithmetic sum of `chip_u1` and `chip_u2`, taking the values 0, 1 or 2 and never 3.
- R7: `word_done` is high for exactly one clock, during the 56th chip of a word. After it, the block is idle with zero outputs until the next load.
- R8: A `load` pulse that arrives while a word is being sent is ignored: the chips of the current word continue unchanged.
- R9: In idle with `load` low, all chip outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master (chip) clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Captures both words when the block is idle |
| word_u1 | input | 8 | Data word for user 1 |
| word_u2 | input | 8 | Data word for user 2 |
| chip_u1 | output | 1 | User 1 spread chip |
| chip_u2 | output | 1 | User 2 spread chip |
| chip_sum | output | 2 | Sum of the two chips |
| word_done | output | 1 | Pulse on the last chip of a word |

## Verification
The assertions assume that `load` is the only input that can start a transfer and that reset is held for at least one clock edge. They also assume that, once `SEND` is entered, nothing outside the block can shorten the 56-chip period. The stimulus respects this: words change only around load strobes. Extra load strobes, with different random words, are driven only in the middle of a transfer, where they must be ignored. Reset is asserted mid-word only as a deliberate corner case, with all checks resuming from a fresh load afterwards.

// File: rtl/cdma_enc_pkg.sv
package cdma_enc_pkg;

    localparam int USERS  = 2;
    localparam int WORD_W = 8;
    localparam int PN_W   = 3;
    localparam int CHIPS  = (1 << PN_W) - 1;
    localparam int SUM_W  = $clog2(USERS + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } enc_state_t;

    function automatic logic [PN_W-1:0] user_seed(input int u);
        return (u == 0) ? 3'b011 : 3'b111;
    endfunction

endpackage

// File: rtl/cdma_pn_lfsr.sv
module cdma_pn_lfsr #(
    parameter int              W    = 3,
    parameter logic [W-1:0]    SEED = 3'b011
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic chip
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            q <= SEED;
        end else begin
            q <= {q[1] ^ q[0], q[W-1:1]};
        end
    end

    assign chip = q[0];
endmodule

// File: rtl/cdma_chip_timer.sv
module cdma_chip_timer #(
    parameter int CHIPS  = 7,
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic bit_end,
    output logic word_end
);
    localparam int CW = $clog2(CHIPS);
    localparam int BW = $clog2(WORD_W);
    localparam logic [CW-1:0] CHIP_LAST = CW'(CHIPS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(WORD_W - 1);

    logic [CW-1:0] chip_cnt;
    logic [BW-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            chip_cnt <= '0;
            bit_cnt  <= '0;
        end else if (run) begin
            if (chip_cnt == CHIP_LAST) begin
                chip_cnt <= '0;
                bit_cnt  <= bit_cnt + 1'b1;
            end else begin
                chip_cnt <= chip_cnt + 1'b1;
            end
        end
    end

    assign bit_end  = run && (chip_cnt == CHIP_LAST);
    assign word_end = bit_end && (bit_cnt == BIT_LAST);
endmodule

// File: rtl/cdma_word_shifter.sv
module cdma_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              shift,
    input  logic [WORD_W-1:0] word,
    output logic              cur_bit
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture) begin
            sr <= word;
        end else if (shift) begin
            sr <= {sr[WORD_W-2:0], 1'b0};
        end
    end

    assign cur_bit = sr[WORD_W-1];
endmodule

// File: rtl/cdma_spread_encoder.sv
module cdma_spread_encoder
    import cdma_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word_u1,
    input  logic [WORD_W-1:0] word_u2,
    output logic              chip_u1,
    output logic              chip_u2,
    output logic [SUM_W-1:0]  chip_sum,
    output logic              word_done
);
    enc_state_t state, state_nx;
    logic       running;
    logic       capture;
    logic       bit_end;
    logic       word_end;

    logic [WORD_W-1:0] words [USERS];
    logic [USERS-1:0]  data_bit;
    logic [USERS-1:0]  pn_chip;
    logic [USERS-1:0]  spread;

    assign words[0] = word_u1;
    assign words[1] = word_u2;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and control outputs
    always_comb begin
        state_nx = state;
        running  = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    capture  = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                running = 1'b1;
                if (word_end) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    cdma_chip_timer #(
        .CHIPS  (CHIPS),
        .WORD_W (WORD_W)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (capture),
        .run      (running),
        .bit_end  (bit_end),
        .word_end (word_end)
    );

    for (genvar u = 0; u < USERS; u++) begin : g_user
        cdma_word_shifter #(
            .WORD_W (WORD_W)
        ) i_shift (
            .clk     (clk),
            .rst     (rst),
            .capture (capture),
            .shift   (bit_end),
            .word    (words[u]),
            .cur_bit (data_bit[u])
        );

        cdma_pn_lfsr #(
            .W    (PN_W),
            .SEED (user_seed(u))
        ) i_pn (
            .clk  (clk),
            .rst  (rst),
            .run  (running),
            .chip (pn_chip[u])
        );

        assign spread[u] = running & data_bit[u] & pn_chip[u];
    end

    assign chip_u1   = spread[0];
    assign chip_u2   = spread[1];
    assign chip_sum  = SUM_W'(spread[0]) + SUM_W'(spread[1]);
    assign word_done = word_end;
endmodule

// File: rtl/cdma_spread_encoder_chk.sv
module cdma_spread_encoder_chk
    import cdma_enc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load,
    input enc_state_t       state,
    input logic             chip_u1,
    input logic             chip_u2,
    input logic [SUM_W-1:0] chip_sum,
    input logic             word_done
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!word_done && chip_sum == '0)) else $error("reset"); // R1
    AST_SUM_LIMIT: assert property (@(posedge clk) disable iff (rst)
        chip_sum != 2'd3) else $error("sum range"); // R6
    AST_SUM_BOTH: assert property (@(posedge clk) disable iff (rst)
        (chip_sum == 2'd2) |-> (chip_u1 && chip_u2)) else $error("sum both"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done) else $error("done width"); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        word_done |=> (!chip_u1 && !chip_u2)) else $error("done idle"); // R7
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && !word_done) |=> state == ST_SEND) else $error("load"); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (chip_sum == '0)) else $error("idle"); // R9
endmodule

bind cdma_spread_encoder cdma_spread_encoder_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .state     (state),
    .chip_u1   (chip_u1),
    .chip_u2   (chip_u2),
    .chip_sum  (chip_sum),
    .word_done (word_done)
);

// File: tb/test_cdma_spread_encoder.sv
module test_cdma_spread_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] word_u1 = '0;
    logic [7:0] word_u2 = '0;
    logic       chip_u1, chip_u2, word_done;
    logic [1:0] chip_sum;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cdma_spread_encoder i_cdma_spread_encoder (
        .clk(clk), .rst(rst), .load(load),
        .word_u1(word_u1), .word_u2(word_u2),
        .chip_u1(chip_u1), .chip_u2(chip_u2),
        .chip_sum(chip_sum), .word_done(word_done)
    );

    function automatic logic sig_chip(input int user, input int k);
        logic [6:0] code;
        code = (user == 0) ? 7'b1100101 : 7'b1110010;
        return code[6-k];
    endfunction

    function automatic logic exp_chip(input int user, input logic [7:0] w, input int c);
        return w[7 - c/7] & sig_chip(user, c % 7);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_check(input string req);
        check(req, chip_u1, 0);
        check(req, chip_u2, 0);
        check(req, chip_sum, 0);
        check(req, word_done, 0);
    endtask

    // send one word pair; junk>0 drives ignored loads mid-word
    task automatic send_word(input logic [7:0] a, input logic [7:0] b, input bit junk);
        logic e1, e2;
        @(negedge clk);
        word_u1 = a; word_u2 = b; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        for (int c = 0; c < 56; c++) begin
            e1 = exp_chip(0, a, c);
            e2 = exp_chip(1, b, c);
            check((a[7 - c/7]) ? "R2/R5" : "R4/R5", chip_u1, e1);
            check((b[7 - c/7]) ? "R3/R5" : "R4/R5", chip_u2, e2);
            check("R6", chip_sum, int'(e1) + int'(e2));
            check("R7", word_done, (c == 55) ? 1 : 0);
            if (junk && (c % 11 == 3)) begin
                load = 1'b1; word_u1 = ~a; word_u2 = ~b;   // R8 stimulus
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
        end
        load = 1'b0;
        idle_check("R7");
    endtask

    initial begin
        void'($urandom(32'd1207));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_check("R1");
        repeat (4) begin
            @(negedge clk);
            idle_check("R9");
        end
        // reference stimulus
        send_word(8'hAA, 8'h55, 1'b0);
        // corners: all ones (overlap -> sum 2), all zeros
        send_word(8'hFF, 8'hFF, 1'b0);
        send_word(8'h00, 8'h00, 1'b0);
        send_word(8'h80, 8'h01, 1'b1);
        // mid-word load must be ignored (R8)
        send_word(8'hAA, 8'h55, 1'b1);
        // random words
        for (int i = 0; i < 12; i++) begin
            send_word(8'($urandom), 8'($urandom), (i % 2) == 1);
        end
        // reset in the middle of a word (R1)
        @(negedge clk);
        word_u1 = 8'hFF; word_u2 = 8'hFF; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle_check("R1");
        @(negedge clk);
        idle_check("R9");
        send_word(8'hC3, 8'h3C, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule